// File: doc/BRIEF.md
# Six-Step Commutation PWM with Deadband

This block drives the three half-bridges of a brushless DC motor for trapezoidal six-step commutation. A free-running up-counter forms the PWM carrier. Its length comes from a maximum period scaled by a Q15 fraction. A 3-bit commutation step picks one sourcing phase, one sinking phase and one floating phase. The sourcing phase carries a complementary PWM pair with deadband inserted. The sinking phase keeps its low-side switch on. Both switches of the floating phase are held off.

The duty input is Q15. When the active-high polarity select is set, the block inverts the duty before it scales it to a compare value. A one-cycle sample strobe fires at the compare point set by half the effective duty, which lies in the middle of the driven pulse. The period, compare points and step are taken into the working set only at the end of a carrier period. A change on the inputs therefore never splits a period.

Top module: `bldc_sixstep_pwm`

## Requirements
- R1: While `rst_n` is low, all six gate outputs and `sample_strobe` are low.
- R2: Phase index 0 is A, 1 is B and 2 is C. Each step value gives a source and sink pair: 0 gives A and B, 1 gives A and C, 2 gives B and C, 3 gives B and A, 4 gives C and A, 5 gives C and B. The sink phase holds `gate_lo` high once `FED` cycles have passed, and its `gate_hi` low. At most one `gate_hi` bit is high at any time.
- R3: The carrier counts 0 up to P and then wraps to 0, so a period lasts P+1 cycles. P = (`period_max` * `period_frac`) >> 15.
- R4: On the source phase the raw PWM signal clears when the counter is 0. It sets when the counter equals C = (P * Deff) >> 15, and zero takes priority. The raw signal is therefore high for P+1-C cycles in each period when C is at least 1.
- R5: Deff is `32767 - duty` when `pol_active_high` is 1 and `duty` when it is 0.
- R6: `sample_strobe` pulses for one cycle each period, in the cycle after the counter equals (P * (Deff >> 1)) >> 15.
- R7: `gate_hi` rises `RED` cycles after the raw signal rises. `gate_lo` rises `FED` cycles after the raw signal falls. Each edge restarts the delay. A raw level shorter than the delay gives no pulse on that side. `gate_hi` and `gate_lo` of one phase are never high together.
- R8: The step, period and compare values are loaded only when the counter wraps to 0. A step change in mid-period leaves the outputs unchanged until the wrap.
- R9: Step values 6 and 7 drive all six gate outputs low.
- R10: The floating phase has both gate outputs low immediately, with no deadband stage in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 3 | Commutation step, 0 to 5 valid |
| duty | input | W-1 | Q15 duty value |
| period_frac | input | W-1 | Q15 period scale |
| period_max | input | W | Maximum carrier period in counts |
| pol_active_high | input | 1 | 1 selects inverted duty |
| gate_hi | output | 3 | High-side gates, bit 0 = A |
| gate_lo | output | 3 | Low-side gates, bit 0 = A |
| sample_strobe | output | 1 | Mid-pulse sample pulse |

## Verification
The deadband assertions assume that `RED` and `FED` are at least 2. They also assume that the step only reaches the gates through the shadow register, so that a change becomes visible at a counter wrap. The inputs are Q15 values by construction, and the random stimulus keeps `period_max` between 16 and 115 so that many periods fit in each segment. Inputs change on falling edges at arbitrary points of a period. This exercises the shadow loading. The directed cases cover both duty extremes in both polarities, pulses shorter than the deadband, and the idle step codes.

// File: rtl/bldc_sixstep_pwm.sv
module bldc_sixstep_pwm #(
  parameter int W   = 16,
  parameter int DBW = 8,
  parameter int RED = 10,
  parameter int FED = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   step,
  input  logic [W-2:0] duty,
  input  logic [W-2:0] period_frac,
  input  logic [W-1:0] period_max,
  input  logic         pol_active_high,
  output logic [2:0]   gate_hi,
  output logic [2:0]   gate_lo,
  output logic         sample_strobe
);
  localparam int PW = 2*W-1;
  localparam logic [DBW-1:0] RED_L = DBW'(RED);
  localparam logic [DBW-1:0] FED_L = DBW'(FED);
  localparam logic [DBW-1:0] AGE_MAX = (RED > FED) ? DBW'(RED) : DBW'(FED);

  logic [W-2:0] duty_eff;
  logic [PW-1:0] prd_prod, cmp_prod, smp_prod;
  logic [W-1:0] prd_new, cmp_new, smp_new;

  assign duty_eff = pol_active_high ? ~duty : duty;
  assign prd_prod = {{(W-1){1'b0}}, period_max} * {{W{1'b0}}, period_frac};
  assign prd_new  = prd_prod[PW-1:W-1];
  assign cmp_prod = {{(W-1){1'b0}}, prd_new} * {{W{1'b0}}, duty_eff};
  assign smp_prod = {{(W-1){1'b0}}, prd_new} * {{(W+1){1'b0}}, duty_eff[W-2:1]};
  assign cmp_new  = cmp_prod[PW-1:W-1];
  assign smp_new  = smp_prod[PW-1:W-1];

  logic [W-1:0] cnt, prd_act, cmp_act, smp_act;
  logic [2:0]   step_act;
  logic         pwm_raw;
  logic         wrap;

  assign wrap = (cnt >= prd_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt           <= '0;
      prd_act       <= '0;
      cmp_act       <= '0;
      smp_act       <= '0;
      step_act      <= 3'd7;
      pwm_raw       <= 1'b0;
      sample_strobe <= 1'b0;
    end else begin
      if (cnt == '0)           pwm_raw <= 1'b0;
      else if (cnt == cmp_act) pwm_raw <= 1'b1;
      sample_strobe <= (cnt == smp_act);
      if (wrap) begin
        cnt      <= '0;
        prd_act  <= prd_new;
        cmp_act  <= cmp_new;
        smp_act  <= smp_new;
        step_act <= step;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  logic [1:0] src_ph, snk_ph;
  always_comb begin
    case (step_act)
      3'd0:    begin src_ph = 2'd0; snk_ph = 2'd1; end
      3'd1:    begin src_ph = 2'd0; snk_ph = 2'd2; end
      3'd2:    begin src_ph = 2'd1; snk_ph = 2'd2; end
      3'd3:    begin src_ph = 2'd1; snk_ph = 2'd0; end
      3'd4:    begin src_ph = 2'd2; snk_ph = 2'd0; end
      3'd5:    begin src_ph = 2'd2; snk_ph = 2'd1; end
      default: begin src_ph = 2'd3; snk_ph = 2'd3; end
    endcase
  end

  for (genvar p = 0; p < 3; p++) begin : g_phase
    logic           is_src, is_snk, a_in, a_q;
    logic [DBW-1:0] age;

    assign is_src = (src_ph == 2'(p));
    assign is_snk = (snk_ph == 2'(p));
    assign a_in   = is_src & pwm_raw;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        a_q <= 1'b0;
        age <= '0;
      end else if (a_in != a_q) begin
        a_q <= a_in;
        age <= '0;
      end else if (age < AGE_MAX) begin
        age <= age + 1'b1;
      end
    end

    assign gate_hi[p] = is_src & a_q & (age >= RED_L);
    assign gate_lo[p] = (is_src | is_snk) & ~a_q & (age >= FED_L);
  end
endmodule

// File: rtl/bldc_sixstep_pwm_chk.sv
module bldc_sixstep_pwm_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   gate_hi,
  input logic [2:0]   gate_lo,
  input logic [W-1:0] cnt,
  input logic [2:0]   step_act
);
  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == 3'b000);

  // R2
  single_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_hi));

  // R2
  lo_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gate_lo) <= 2);

  // R8
  step_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(step_act) |-> cnt == '0);

  // R9
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_act >= 3'd6 |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

  for (genvar p = 0; p < 3; p++) begin : g_db
    // R7
    hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi[p]) |-> (!$past(gate_lo[p]) && !$past(gate_lo[p], 2)));
    // R7
    lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo[p]) |-> (!$past(gate_hi[p]) && !$past(gate_hi[p], 2)));
  end
endmodule

bind bldc_sixstep_pwm bldc_sixstep_pwm_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gate_hi  (gate_hi),
  .gate_lo  (gate_lo),
  .cnt      (cnt),
  .step_act (step_act)
);

// File: tb/tb_bldc_sixstep_pwm.sv
`timescale 1ns/1ps
module tb_bldc_sixstep_pwm;
  localparam int W = 16;
  localparam int RED = 10;
  localparam int FED = 10;
  localparam int AGE_MAX = (RED > FED) ? RED : FED;
  localparam longint QMAX = (64'd1 << (W-1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]   step = '0;
  logic [W-2:0] duty = '0;
  logic [W-2:0] period_frac = '0;
  logic [W-1:0] period_max = '0;
  logic         pol_active_high = 1'b0;
  logic [2:0]   gate_hi, gate_lo;
  logic         sample_strobe;

  always #4 clk = ~clk;

  bldc_sixstep_pwm #(.W(W), .RED(RED), .FED(FED)) dut (
    .clk(clk), .rst_n(rst_n), .step(step), .duty(duty),
    .period_frac(period_frac), .period_max(period_max),
    .pol_active_high(pol_active_high), .gate_hi(gate_hi),
    .gate_lo(gate_lo), .sample_strobe(sample_strobe)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic longint f_prd(longint pm, longint pf);
    return (pm * pf) >> (W-1);
  endfunction
  function automatic longint f_eff(longint d, bit pol);
    return pol ? (QMAX - d) : d;
  endfunction
  function automatic int f_src(int s);
    case (s)
      0, 1: return 0;
      2, 3: return 1;
      4, 5: return 2;
      default: return 3;
    endcase
  endfunction
  function automatic int f_snk(int s);
    case (s)
      0: return 1;
      1, 2: return 2;
      3, 4: return 0;
      5: return 1;
      default: return 3;
    endcase
  endfunction

  // reference model built from the requirements
  longint m_cnt, m_prd, m_cmp, m_smp, m_eff;
  int m_step;
  bit m_raw, m_str, m_nraw, m_ain;
  bit m_aq [3];
  int m_age [3];
  int m_src;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_prd = 0; m_cmp = 0; m_smp = 0; m_step = 7;
      m_raw = 0; m_str = 0;
      for (int p = 0; p < 3; p++) begin m_aq[p] = 0; m_age[p] = 0; end
    end else begin
      m_src = f_src(m_step);
      for (int p = 0; p < 3; p++) begin
        m_ain = (m_src == p) && m_raw;
        if (m_ain != m_aq[p]) begin m_aq[p] = m_ain; m_age[p] = 0; end
        else if (m_age[p] < AGE_MAX) m_age[p]++;
      end
      m_nraw = m_raw;
      if (m_cnt == 0) m_nraw = 0;
      else if (m_cnt == m_cmp) m_nraw = 1;
      m_str = (m_cnt == m_smp);
      m_raw = m_nraw;
      if (m_cnt >= m_prd) begin
        m_cnt = 0;
        m_prd = f_prd(period_max, period_frac);
        m_eff = f_eff(duty, pol_active_high);
        m_cmp = (m_prd * m_eff) >> (W-1);
        m_smp = (m_prd * (m_eff >> 1)) >> (W-1);
        m_step = step;
      end else begin
        m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [2:0] e_hi, e_lo;
      for (int p = 0; p < 3; p++) begin
        e_hi[p] = (f_src(m_step) == p) && m_aq[p] && (m_age[p] >= RED);
        e_lo[p] = ((f_src(m_step) == p) || (f_snk(m_step) == p)) && !m_aq[p] && (m_age[p] >= FED);
      end
      chk("R4 gate_hi vs model", gate_hi, e_hi);
      chk("R7 gate_lo vs model", gate_lo, e_lo);
      chk("R6 sample_strobe vs model", sample_strobe, m_str);
    end
  end

  int hi_n [3];
  int lo_n [3];

  task automatic measure(int n);
    for (int p = 0; p < 3; p++) begin hi_n[p] = 0; lo_n[p] = 0; end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        hi_n[p] += gate_hi[p];
        lo_n[p] += gate_lo[p];
      end
    end
  endtask

  task automatic wait_strobe();
    for (int i = 0; i < 300 && !sample_strobe; i++) @(negedge clk);
    chk("R6 strobe seen", sample_strobe, 1);
  endtask

  task automatic setup(int s, longint d, bit pol);
    step = 3'(s); duty = (W-1)'(d); pol_active_high = pol;
  endtask

  initial begin
    #(8 * 190000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int unsigned seed_init;
    int n;
    seed_init = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk("R1 gate_hi in reset", gate_hi, 0);
    chk("R1 gate_lo in reset", gate_lo, 0);
    chk("R1 strobe in reset", sample_strobe, 0);
    period_max = 16'd64; period_frac = 15'h4000;  // P = 32
    setup(0, 15'h2000, 0);                          // C = 8
    rst_n = 1'b1;
    repeat (100) @(negedge clk);

    wait_strobe();
    n = 0;
    do begin @(negedge clk); n++; end while (!sample_strobe && n < 300);
    chk("R3 period length", n, 33);

    measure(33);
    chk("R4 source high time", hi_n[0], 33 - 8 - RED);
    chk("R2 sink low side on", lo_n[1], 33);
    chk("R2 sink high side off", hi_n[1], 0);
    chk("R10 float high off", hi_n[2], 0);
    chk("R10 float low off", lo_n[2], 0);

    setup(0, 15'h6000, 1);                          // Deff = 0x1FFF, C = 7
    repeat (70) @(negedge clk);
    measure(33);
    chk("R5 inverted duty high time", hi_n[0], 33 - 7 - RED);

    setup(0, 15'h6000, 0);                          // C = 24, raw high 9
    repeat (70) @(negedge clk);
    measure(33);
    chk("R7 short pulse suppressed", hi_n[0], 0);
    chk("R7 low side after delay", lo_n[0], 24 - FED);

    setup(0, 15'h6000, 1);
    repeat (70) @(negedge clk);
    wait_strobe();
    step = 3'd7;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R8 sink held until wrap", gate_lo[1], 1);
    end
    repeat (40) @(negedge clk);
    measure(66);
    chk("R9 idle high sides", hi_n[0] + hi_n[1] + hi_n[2], 0);
    chk("R9 idle low sides", lo_n[0] + lo_n[1] + lo_n[2], 0);

    setup(2, 15'h6000, 1);
    repeat (70) @(negedge clk);
    measure(33);
    chk("R10 float A high", hi_n[0], 0);
    chk("R10 float A low", lo_n[0], 0);
    chk("R2 sink C low", lo_n[2], 33);
    chk("R2 source B high", hi_n[1], 33 - 7 - RED);

    setup(6, 15'h1000, 0);
    repeat (40) @(negedge clk);
    measure(33);
    chk("R9 step 6 off", hi_n[0] + hi_n[1] + hi_n[2] + lo_n[0] + lo_n[1] + lo_n[2], 0);

    for (int c = 0; c < 4; c++) begin
      setup(3, (c % 2) ? QMAX : 0, c / 2);
      repeat (100) @(negedge clk);
    end

    for (int seg = 0; seg < 120; seg++) begin
      @(negedge clk);
      step = 3'($urandom % 8);
      pol_active_high = 1'($urandom % 2);
      duty = (W-1)'($urandom % 32768);
      period_frac = (W-1)'(16'h1000 + ($urandom % 16'h7000));
      period_max = W'(16 + ($urandom % 100));
      repeat (20 + ($urandom % 250)) @(negedge clk);
    end
    finish_run();
  end
endmodule